// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records when something happens on a set of auxiliary input pins. It watches each pin through a short synchroniser and an edge detector. When an edge selected for that channel is seen, it stores the value of the free-running 64-bit time counter in that channel's capture register. It then sets the channel's pending flag. A shared interrupt line tells software that at least one enabled channel holds a fresh capture.

Software sets up each channel through a small control field: one bit arms capture on rising edges, one bit arms capture on falling edges, and one bit lets the channel drive the shared interrupt. Software reads the captured time as a low word and a high word, then clears the pending flag by writing one to it. An edge that arrives while a capture is still unread is dropped, and a sticky overflow flag records the loss. The global event enable behind the interrupt follows channel activity. Any control write that arms at least one edge turns it on. A control write with no edge bits turns it off once no channel is left armed.

Top module: `evt_capture_unit`

## Requirements
- R1: A level change on a pin is first sampled at some rising clock edge. The capture takes the time input as it stands at the second rising clock edge after that one, and the pending flag is set by that same edge.
- R2: Control word bit 0 arms capture on rising pin edges and bit 1 arms capture on falling pin edges. With both bits set, either edge captures. An edge of a kind that is not armed does not capture.
- R3: A channel whose control edge bits are both zero never captures and never sets its pending flag, whatever its pin does.
- R4: Register address = {global bit, channel index, 2-bit select}. Select 0 is control, select 1 the low 32 bits of the capture, select 2 the high 32 bits, select 3 status. The capture words are read-only, and writes to them leave them unchanged.
- R5: Status bit 0 is the pending flag. A capture sets it, and writing status with bit 0 set clears it.
- R6: An armed edge that arrives while the pending flag is set is dropped. The stored capture is kept, and status bit 1 (overflow) is set. Writing status with bit 1 set clears it.
- R7: The interrupt output is high exactly when the global event enable is set and some channel has both its pending flag and its control bit 2 (interrupt enable) set.
- R8: The global register (address with the top bit set) reads the global event enable in bit 0 and the per-channel pending flags in bits NUM_CH..1. The enable is set by a control write whose edge bits are not both zero. It is cleared by a control write with both edge bits zero when no other channel has an edge bit set.
- R9: After reset, every control, capture and status field reads zero, the global register reads zero, and the interrupt is low.
- R10: Channels are independent: a capture, clear or overflow on one channel leaves every other channel's status and capture unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Free-running time counter value |
| evt_pin | input | NUM_CH | Asynchronous auxiliary event inputs, one per channel |
| reg_addr | input | ADDR_W | Register address; reads are combinational on this address |
| reg_wr | input | 1 | Write strobe, acts on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 1 | Shared event interrupt |

## Verification
The assertions take for granted that each pin holds a level for at least one clock period before changing, so that the synchroniser does not skip a transition. They also assume that software writes one register per cycle. The stimulus holds every pin level for four cycles and spaces register accesses a full cycle apart. It also never clears a pending flag in the same cycle as an edge arrives, so the order between a clear and a drop is never relied upon.

// File: rtl/evtcap_pkg.sv
package evtcap_pkg;
  // control word fields
  localparam int CTRL_RISE = 0;
  localparam int CTRL_FALL = 1;
  localparam int CTRL_IE   = 2;
  localparam int CTRL_W    = 3;
  // status word fields
  localparam int ST_PEND = 0;
  localparam int ST_OVF  = 1;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CAP_LO = 2'd1,
    SEL_CAP_HI = 2'd2,
    SEL_STAT   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ie;
    logic fall_en;
    logic rise_en;
  } chan_ctrl_t;
endpackage

// File: rtl/evtcap_sync_edge.sv
module evtcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // newest synchronised level vs the one before it
  assign rise_o =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/evtcap_channel.sv
module evtcap_channel
  import evtcap_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              ctrl_we,
  input  chan_ctrl_t        ctrl_wdata,
  input  logic              stat_we,
  input  logic [1:0]        stat_clr,
  output chan_ctrl_t        ctrl_o,
  output logic              act_o,
  output logic              pend_o,
  output logic              ovf_o,
  output logic [TIME_W-1:0] cap_o
);
  chan_ctrl_t        ctrl_q, ctrl_d;
  logic              pend_q, pend_d;
  logic              ovf_q, ovf_d;
  logic [TIME_W-1:0] cap_q;
  logic              hit, take, drop;

  assign hit  = (rise_i & ctrl_q.rise_en) | (fall_i & ctrl_q.fall_en);
  assign take = hit & ~pend_q;
  assign drop = hit &  pend_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_wdata;

    pend_d = pend_q;
    if (stat_we && stat_clr[ST_PEND]) pend_d = 1'b0;
    if (take) pend_d = 1'b1;

    ovf_d = ovf_q;
    if (stat_we && stat_clr[ST_OVF]) ovf_d = 1'b0;
    if (drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  // capture register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap_q <= '0;
    else if (take) cap_q <= time_i;
  end

  assign ctrl_o = ctrl_q;
  assign act_o  = ctrl_q.rise_en | ctrl_q.fall_en;
  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/evtcap_global.sv
module evtcap_global #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ctrl_we,
  input  logic              wr_arms,
  input  logic [NUM_CH-1:0] act,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] ie,
  output logic              gev_en_o,
  output logic              irq_o
);
  logic gev_q, gev_d;
  logic others_act;

  assign others_act = |(act & ~ctrl_we);

  always_comb begin
    gev_d = gev_q;
    if (|ctrl_we) begin
      if (wr_arms)          gev_d = 1'b1;
      else if (!others_act) gev_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gev_q <= 1'b0;
    else        gev_q <= gev_d;
  end

  assign gev_en_o = gev_q;
  assign irq_o    = gev_q & (|(pend & ie));
endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit
  import evtcap_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int TIME_W     = 2 * DATA_W,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W     = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic [NUM_CH-1:0] evt_pin,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic                     glb_sel;
  logic [CH_W-1:0]          ch_idx;
  reg_sel_e                 sel;
  logic [NUM_CH-1:0]        ctrl_we, stat_we;
  logic [NUM_CH-1:0]        act_all, pend_all, ovf_all, ie_all;
  logic [NUM_CH*TIME_W-1:0] cap_flat;
  chan_ctrl_t               ctrl_all [NUM_CH];
  chan_ctrl_t               ctrl_wd;
  logic                     gev_en;
  logic                     unused_wdata;

  assign glb_sel      = reg_addr[ADDR_W-1];
  assign ch_idx       = reg_addr[ADDR_W-2:2];
  assign sel          = reg_sel_e'(reg_addr[1:0]);
  assign ctrl_wd      = chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_W];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic rise_w, fall_w;
      logic hit_addr;

      assign hit_addr   = reg_wr && !glb_sel && (ch_idx == CH_W'(g));
      assign ctrl_we[g] = hit_addr && (sel == SEL_CTRL);
      assign stat_we[g] = hit_addr && (sel == SEL_STAT);

      evtcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (evt_pin[g]),
        .rise_o (rise_w),
        .fall_o (fall_w)
      );

      evtcap_channel #(.TIME_W(TIME_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .time_i     (time_i),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .ctrl_we    (ctrl_we[g]),
        .ctrl_wdata (ctrl_wd),
        .stat_we    (stat_we[g]),
        .stat_clr   (reg_wdata[1:0]),
        .ctrl_o     (ctrl_all[g]),
        .act_o      (act_all[g]),
        .pend_o     (pend_all[g]),
        .ovf_o      (ovf_all[g]),
        .cap_o      (cap_flat[g*TIME_W +: TIME_W])
      );

      assign ie_all[g] = ctrl_all[g].ie;
    end
  endgenerate

  evtcap_global #(.NUM_CH(NUM_CH)) u_glb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_we),
    .wr_arms  (ctrl_wd.rise_en | ctrl_wd.fall_en),
    .act      (act_all),
    .pend     (pend_all),
    .ie       (ie_all),
    .gev_en_o (gev_en),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (glb_sel) begin
      reg_rdata[0]        = gev_en;
      reg_rdata[NUM_CH:1] = pend_all;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == CH_W'(c)) begin
          case (sel)
            SEL_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_all[c];
            SEL_CAP_LO: reg_rdata = cap_flat[c*TIME_W +: DATA_W];
            SEL_CAP_HI: reg_rdata = cap_flat[c*TIME_W+DATA_W +: DATA_W];
            default:    reg_rdata[1:0] = {ovf_all[c], pend_all[c]};
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/evt_capture_unit_chk.sv
module evt_capture_unit_chk #(
  parameter int NUM_CH = 4,
  parameter int TIME_W = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq,
  input logic                     gev_en,
  input logic [NUM_CH-1:0]        act,
  input logic [NUM_CH-1:0]        pend,
  input logic [NUM_CH-1:0]        ovf,
  input logic [NUM_CH*TIME_W-1:0] cap_flat
);
  AST_IRQ_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gev_en); // R7

  AST_GLOBAL_TRACKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    gev_en == (|act)); // R8

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_chk
      AST_NO_CAPTURE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[i]) |-> $past(act[i])); // R3

      AST_OVERFLOW_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf[i]) |-> $past(pend[i])); // R6

      AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        pend[i] |=> $stable(cap_flat[i*TIME_W +: TIME_W])); // R6
    end
  endgenerate
endmodule

bind evt_capture_unit evt_capture_unit_chk #(
  .NUM_CH (NUM_CH),
  .TIME_W (TIME_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq_o),
  .gev_en   (gev_en),
  .act      (act_all),
  .pend     (pend_all),
  .ovf      (ovf_all),
  .cap_flat (cap_flat)
);

// File: tb/evt_capture_unit_test.sv
module evt_capture_unit_test;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int ADDR_W = CH_W + 3;
  localparam logic [ADDR_W-1:0] GLB = 5'b10000;

  typedef struct {
    bit                is_irq;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       exp;
    string             req;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [63:0]       tcnt = 64'h0000_00A5_FFFF_FFE0;
  logic [NUM_CH-1:0] evt_pin = '0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  sb_item_t sbq[$];

  always #10 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 64'd1;

  evt_capture_unit uut (
    .clk(clk), .rst_n(rst_n), .time_i(tcnt), .evt_pin(evt_pin),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [ADDR_W-1:0] ra(int ch, int s);
    return {1'b0, CH_W'(ch), 2'(s)};
  endfunction

  task automatic expect_reg(logic [ADDR_W-1:0] a, logic [31:0] e, string r);
    sbq.push_back('{is_irq: 1'b0, addr: a, exp: e, req: r});
  endtask

  task automatic expect_irq(bit e, string r);
    sbq.push_back('{is_irq: 1'b1, addr: '0, exp: {31'b0, e}, req: r});
  endtask

  // monitor: pop expected items and compare against the design
  task automatic monitor_drain();
    logic [31:0] act;
    while (sbq.size() > 0) begin
      sb_item_t it = sbq.pop_front();
      @(negedge clk); #2;
      if (it.is_irq) act = {31'b0, irq_o};
      else begin
        reg_addr = it.addr; #1; act = reg_rdata;
      end
      n_total++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0h actual=%0h expected=%0h", it.req, it.addr, act, it.exp);
      end
    end
  endtask

  task automatic reg_write(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #2;
    reg_wr = 1'b0;
  endtask

  // returns the time value the capture is expected to hold (R1)
  task automatic drive_pin(int ch, bit lvl, output logic [63:0] exp_t);
    @(negedge clk); #1;
    exp_t = tcnt + 64'd2;
    evt_pin[ch] = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [63:0] t0, t1, dummy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    expect_reg(ra(0, 0), 32'h0, "R9");
    expect_reg(ra(0, 3), 32'h0, "R9");
    expect_reg(ra(2, 1), 32'h0, "R9");
    expect_reg(GLB, 32'h0, "R9");
    expect_irq(1'b0, "R9");
    monitor_drain();

    // channel 0: rising + interrupt enable; R8 global enable
    reg_write(ra(0, 0), 32'h5);
    expect_reg(ra(0, 0), 32'h5, "R2");
    expect_reg(GLB, 32'h1, "R8");
    monitor_drain();

    drive_pin(0, 1'b1, t0);
    expect_reg(ra(0, 1), t0[31:0], "R1");
    expect_reg(ra(0, 2), t0[63:32], "R4");
    expect_reg(ra(0, 3), 32'h1, "R5");
    expect_reg(GLB, 32'h3, "R8");
    expect_irq(1'b1, "R7");
    monitor_drain();

    // capture words are read-only (R4)
    reg_write(ra(0, 1), 32'hDEAD_BEEF);
    expect_reg(ra(0, 1), t0[31:0], "R4");
    monitor_drain();

    // clear pending (R5), then falling edge is not armed (R2)
    reg_write(ra(0, 3), 32'h1);
    expect_reg(ra(0, 3), 32'h0, "R5");
    expect_irq(1'b0, "R7");
    monitor_drain();
    drive_pin(0, 1'b0, dummy);
    expect_reg(ra(0, 3), 32'h0, "R2");
    expect_reg(ra(0, 1), t0[31:0], "R2");
    monitor_drain();

    // channel 1: falling only, no interrupt enable
    reg_write(ra(1, 0), 32'h2);
    drive_pin(1, 1'b1, dummy);
    expect_reg(ra(1, 3), 32'h0, "R2");
    monitor_drain();
    drive_pin(1, 1'b0, t1);
    expect_reg(ra(1, 1), t1[31:0], "R2");
    expect_reg(ra(1, 2), t1[63:32], "R4");
    expect_reg(ra(1, 3), 32'h1, "R5");
    expect_irq(1'b0, "R7");
    expect_reg(ra(0, 3), 32'h0, "R10");
    monitor_drain();

    // overflow: another falling edge while pending (R6)
    drive_pin(1, 1'b1, dummy);
    drive_pin(1, 1'b0, dummy);
    expect_reg(ra(1, 3), 32'h3, "R6");
    expect_reg(ra(1, 1), t1[31:0], "R6");
    expect_reg(ra(0, 3), 32'h0, "R10");
    monitor_drain();
    reg_write(ra(1, 3), 32'h2);
    expect_reg(ra(1, 3), 32'h1, "R6");
    monitor_drain();
    reg_write(ra(1, 3), 32'h1);
    expect_reg(ra(1, 3), 32'h0, "R5");
    monitor_drain();

    // channel 2: both edges
    reg_write(ra(2, 0), 32'h7);
    drive_pin(2, 1'b1, t0);
    expect_reg(ra(2, 1), t0[31:0], "R2");
    expect_irq(1'b1, "R7");
    monitor_drain();
    reg_write(ra(2, 3), 32'h1);
    drive_pin(2, 1'b0, t1);
    expect_reg(ra(2, 1), t1[31:0], "R2");
    expect_reg(ra(2, 2), t1[63:32], "R2");
    expect_reg(ra(2, 3), 32'h1, "R5");
    monitor_drain();

    // channel 3 left off: no capture (R3)
    drive_pin(3, 1'b1, dummy);
    drive_pin(3, 1'b0, dummy);
    expect_reg(ra(3, 3), 32'h0, "R3");
    expect_reg(ra(3, 1), 32'h0, "R3");
    monitor_drain();

    // disabling channels: global enable follows (R8)
    reg_write(ra(0, 0), 32'h0);
    reg_write(ra(1, 0), 32'h0);
    expect_reg(GLB, 32'h9, "R8");
    monitor_drain();
    reg_write(ra(2, 0), 32'h4);
    expect_reg(GLB, 32'h8, "R8");
    expect_irq(1'b0, "R7");
    expect_reg(ra(2, 3), 32'h1, "R10");
    monitor_drain();
    drive_pin(2, 1'b1, dummy);
    expect_reg(ra(2, 1), t1[31:0], "R3");
    monitor_drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule